// File: doc/BRIEF.md
# Streaming CRC-32 Checksum Unit

This unit runs alongside a byte-wide data stream and folds every accepted byte into a CRC-32 accumulator. It uses the reflected CRC-32 polynomial 0xEDB88320. The accumulator starts at 0xFFFFFFFF, and the presented result is XORed with 0xFFFFFFFF. It absorbs one byte per clock cycle. A byte is taken only while the enable is high and the byte strobe is valid. A byte flagged as the end of a frame produces a one-cycle completion pulse on the following cycle.

Two run-time selections shape the arithmetic. The first swaps the bit order of each incoming byte before it enters the CRC. The second bit-reverses the 32-bit result as it leaves the block. A synchronous clear returns the accumulator to its start value between frames. The unit does not decode a register bus, gather interrupts or move any data.

Top module: `crc32_stream_unit`

## Requirements
- R1: With both selections low, the presented result is the standard reflected CRC-32 of the accepted bytes. The polynomial is 0xEDB88320, the initial value is 0xFFFFFFFF and the final XOR is 0xFFFFFFFF. The ASCII string "123456789" yields 0xCBF43926.
- R2: A byte is accepted on a rising clock edge when `crc_en`, `byte_valid` and `rst_n` are high and `crc_clr` is low. The result reflects that byte from the cycle after that edge.
- R3: A byte presented while `crc_en` is low is ignored. The accumulator and the result are unchanged, and no completion pulse follows.
- R4: When `crc_clr` is high at a rising edge, the accumulator returns to 0xFFFFFFFF, so the result reads 0x00000000. A byte offered in the same cycle is discarded, and its end-of-frame flag produces no pulse.
- R5: When `in_bit_swap` is high, bit 7 of an accepted byte is exchanged with bit 0, bit 6 with bit 1, and so on, before the byte is absorbed.
- R6: When `out_reverse` is high, result bit i carries the bit that would otherwise appear at bit 31-i. The selection acts combinationally on the stored state, in the same cycle it changes.
- R7: `crc_done` is high for exactly the one cycle after a byte with `byte_last` high is accepted. It stays low after every other byte.
- R8: With `rst_n` low at a rising edge, the accumulator is reset to 0xFFFFFFFF and `crc_done` to 0.
- R9: While no byte is accepted and `crc_clr` is low, the result holds its value, provided `out_reverse` is steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_en | input | 1 | Accumulation enable |
| crc_clr | input | 1 | Synchronous accumulator clear, has priority over data |
| in_bit_swap | input | 1 | Reverse the bit order of each incoming byte |
| out_reverse | input | 1 | Bit-reverse the 32-bit result |
| byte_valid | input | 1 | Byte strobe of the data stream |
| byte_data | input | 8 | Byte of the data stream |
| byte_last | input | 1 | Marks the final byte of a frame |
| crc_value | output | 32 | Presented CRC result |
| crc_done | output | 1 | One-cycle pulse after the final byte is absorbed |

## Verification
The assertions assume that the control inputs change only between clock edges. They also assume that `byte_last` carries meaning only alongside `byte_valid`. The stability property further assumes that `out_reverse` stays steady across the cycles it compares. The bench drives every input on the falling edge and lowers `byte_last` together with `byte_valid`. It changes `out_reverse` only in cycles where the stability check is explicitly excused.

// File: rtl/crc32_pkg.sv
// Package: shared constants of the streaming CRC-32 unit.
// Assumes a reflected (LSB-first) CRC whose state is as wide as the polynomial.
package crc32_pkg;
    localparam int unsigned CRC_W    = 32;
    localparam int unsigned BYTE_W   = 8;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_XOR_OUT   = 32'hFFFF_FFFF;
endpackage

// File: rtl/crc_bit_order.sv
// Module: optional bit-order swap of one incoming data unit.
// Assumes the swap select is static within a cycle; purely combinational.
module crc_bit_order #(
    parameter int unsigned W = 8
) (
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // One mux per bit: straight or mirrored position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = swap ? din[W-1-i] : din[i];
    end
endmodule

// File: rtl/crc_byte_step.sv
// Module: advances a reflected CRC state by one data unit (all bits in one cycle).
// Assumes LSB-first absorption; the polynomial is given in reflected form.
module crc_byte_step #(
    parameter int unsigned          CW   = 32,
    parameter int unsigned          DW   = 8,
    parameter logic [CW-1:0]        POLY = 32'hEDB8_8320
) (
    input  logic [CW-1:0] state_in,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] state_out
);
    localparam int unsigned PAD_W = CW - DW;

    // Unrolled shift-and-conditional-XOR over every bit of the unit.
    always_comb begin
        logic [CW-1:0] s;
        s = state_in ^ {{PAD_W{1'b0}}, data_in};
        for (int b = 0; b < DW; b++) begin
            s = s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
        end
        state_out = s;
    end
endmodule

// File: rtl/crc_result_fmt.sv
// Module: turns the raw CRC state into the presented value (final XOR, optional reversal).
// Assumes the reversal select may change at any time; output follows it combinationally.
module crc_result_fmt #(
    parameter int unsigned   CW      = 32,
    parameter logic [CW-1:0] XOR_OUT = 32'hFFFF_FFFF
) (
    input  logic          reverse,
    input  logic [CW-1:0] state,
    output logic [CW-1:0] value
);
    logic [CW-1:0] fin;

    // Final XOR of the accumulator.
    assign fin = state ^ XOR_OUT;

    // Per-bit selection between straight and mirrored result.
    for (genvar i = 0; i < CW; i++) begin : g_rev
        assign value[i] = reverse ? fin[CW-1-i] : fin[i];
    end
endmodule

// File: rtl/crc32_stream_unit.sv
// Module: CRC-32 accumulator beside a byte-wide stream with a frame-end done pulse.
// Assumes inputs settle between clock edges; byte_last is only meaningful with byte_valid.
// Clear has priority over an offered byte; reset is synchronous and active low.
module crc32_stream_unit
    import crc32_pkg::*;
#(
    parameter int unsigned        DATA_W   = BYTE_W,
    parameter int unsigned        STATE_W  = CRC_W,
    parameter logic [STATE_W-1:0] POLY     = CRC_POLY_REFL,
    parameter logic [STATE_W-1:0] SEED     = CRC_SEED,
    parameter logic [STATE_W-1:0] XOR_OUT  = CRC_XOR_OUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_en,
    input  logic              crc_clr,
    input  logic              in_bit_swap,
    input  logic              out_reverse,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_last,
    output logic [31:0]       crc_value,
    output logic              crc_done
);
    logic [STATE_W-1:0] acc_q;
    logic [STATE_W-1:0] acc_next;
    logic [DATA_W-1:0]  unit_ordered;
    logic               take;
    logic [STATE_W-1:0] shown;

    // Acceptance: enabled, valid and not overridden by clear.
    assign take = crc_en && byte_valid && !crc_clr;

    crc_bit_order #(.W(DATA_W)) u_order (
        .swap (in_bit_swap),
        .din  (byte_data),
        .dout (unit_ordered)
    );

    crc_byte_step #(.CW(STATE_W), .DW(DATA_W), .POLY(POLY)) u_step (
        .state_in  (acc_q),
        .data_in   (unit_ordered),
        .state_out (acc_next)
    );

    crc_result_fmt #(.CW(STATE_W), .XOR_OUT(XOR_OUT)) u_fmt (
        .reverse (out_reverse),
        .state   (acc_q),
        .value   (shown)
    );

    assign crc_value = shown[31:0];

    // Accumulator register: reset/clear to seed, else absorb an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || crc_clr) begin
            acc_q <= SEED;
        end else if (take) begin
            acc_q <= acc_next;
        end
    end

    // Done flag: one-cycle pulse after an accepted frame-end byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_done <= 1'b0;
        end else begin
            crc_done <= take && byte_last;
        end
    end

    AST_HOLD_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_en && !crc_clr) |=> $stable(acc_q)) else $error("hold"); // R3
    AST_CLEAR_TO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        crc_clr |=> (acc_q == SEED)) else $error("clear"); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && byte_valid && byte_last && !crc_clr) |=> crc_done) else $error("done"); // R7
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |-> $past(crc_en && byte_valid && byte_last && !crc_clr)) else $error("cause"); // R7
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(crc_en && byte_valid) && !crc_clr && $stable(out_reverse)) |=> $stable(crc_value)) else $error("stable"); // R9
endmodule

// File: tb/test_crc32_stream_unit.sv
module test_crc32_stream_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b0;
    logic        crc_clr = 1'b0;
    logic        in_bit_swap = 1'b0;
    logic        out_reverse = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        byte_last = 1'b0;
    logic [31:0] crc_value;
    logic        crc_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    crc32_stream_unit i_crc32_stream_unit (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .crc_clr(crc_clr),
        .in_bit_swap(in_bit_swap), .out_reverse(out_reverse),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .crc_value(crc_value), .crc_done(crc_done)
    );

    function automatic logic [31:0] m_rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] m_step(input logic [31:0] c, input logic [7:0] b, input logic sw);
        logic [7:0] x;
        for (int i = 0; i < 8; i++) x[i] = sw ? b[7-i] : b[i];
        c = c ^ {24'h0, x};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c;
    endfunction

    function automatic logic [31:0] m_view(input logic [31:0] c, input logic rv);
        return rv ? m_rev32(~c) : ~c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Offer one byte at the falling edge; return at the next falling edge.
    task automatic offer(input logic [7:0] d, input logic last);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = d; byte_last = last;
        @(negedge clk);
        byte_valid = 1'b0; byte_last = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        crc_clr = 1'b1;
        @(negedge clk);
        crc_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] m;
        logic [7:0] msg [9];
        msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 value", crc_value, 32'h0);
        check("R8 done", {31'h0, crc_done}, 32'h0);
        rst_n = 1'b1;
        crc_en = 1'b1;

        // R1/R7: known check string
        m = 32'hFFFFFFFF;
        for (int i = 0; i < 9; i++) begin
            offer(msg[i], i == 8);
            check("R7 done level", {31'h0, crc_done}, {31'h0, i == 8});
        end
        check("R1 check string", crc_value, 32'hCBF43926);
        @(negedge clk);
        check("R7 done one cycle", {31'h0, crc_done}, 32'h0);
        check("R9 result held", crc_value, 32'hCBF43926);

        // R6: output reversal acts in the same cycle
        out_reverse = 1'b1;
        #1 check("R6 live reverse", crc_value, m_rev32(32'hCBF43926));
        out_reverse = 1'b0;

        // R3: enable low ignores the byte
        crc_en = 1'b0;
        offer(8'hA5, 1'b1);
        check("R3 value kept", crc_value, 32'hCBF43926);
        check("R3 no done", {31'h0, crc_done}, 32'h0);
        crc_en = 1'b1;

        // R4: clear beats a byte in the same cycle
        @(negedge clk);
        crc_clr = 1'b1; byte_valid = 1'b1; byte_data = 8'h5A; byte_last = 1'b1;
        @(negedge clk);
        crc_clr = 1'b0; byte_valid = 1'b0; byte_last = 1'b0;
        check("R4 cleared", crc_value, 32'h0);
        check("R4 no done", {31'h0, crc_done}, 32'h0);

        // R2/R5/R6: every byte value under each selection pair
        for (int mode = 0; mode < 4; mode++) begin
            in_bit_swap = mode[0];
            out_reverse = mode[1];
            for (int b = 0; b < 256; b++) begin
                pulse_clear();
                offer(8'(b), 1'b1);
                m = m_step(32'hFFFFFFFF, 8'(b), mode[0]);
                check(mode[0] ? "R5 swapped byte" : "R2 single byte", crc_value, m_view(m, mode[1]));
                check("R7 sweep done", {31'h0, crc_done}, 32'h1);
            end
        end

        // R2: multi-byte frame with swap, no frame end until the last byte
        in_bit_swap = 1'b1; out_reverse = 1'b0;
        pulse_clear();
        m = 32'hFFFFFFFF;
        for (int i = 0; i < 16; i++) begin
            offer(8'(i * 37 + 11), i == 15);
            m = m_step(m, 8'(i * 37 + 11), 1'b1);
            check("R2 running value", crc_value, m_view(m, 1'b0));
        end

        // R8: reset mid-frame
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R8 mid reset", crc_value, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule